// File: doc/BRIEF.md
# SM3 TT1 Round-Step Vector Unit

This unit carries out one compression step of the SM3 hash on 128-bit vectors held in an external register file. It receives a 32-bit instruction word under a valid/ready handshake and decodes the fixed opcode bits. It then reads three vector operands through a combinational read port: the accumulator, which is also the destination, a second source and a third source. In the same cycle it forms a new top lane from four terms added modulo 2^32: a bitwise majority of three accumulator lanes, the accumulator's bottom lane, a rotated-XOR term and a message word picked from the third source by a 2-bit lane index. It also shifts the other accumulator lanes down by one lane and rotates one of them.

The 128-bit result passes through one register stage. It comes out on the next cycle together with a completion strobe, the destination index and a write enable. A word that fails the opcode match completes with an undefined-instruction flag, and its write enable stays low.

A three-state controller drives the handshake. `ST_OFF` is the state held in reset and for the first cycle after it, with ready low. `ST_IDLE` means no result is pending. `ST_RESULT` means the output register holds a completed instruction. The transitions are `ST_OFF -> ST_IDLE` on the first clock after reset. Any state other than `ST_OFF` moves to `ST_RESULT` when an instruction is accepted. `ST_RESULT -> ST_IDLE` happens when no instruction is accepted. The unit accepts one instruction per cycle. Latency is always one cycle, whatever the operand values.

Top module: `sm3s_step_unit`

## Requirements
- R1: An instruction is recognised only when bits [31:21] equal 11001110010, bits [15:14] equal 10 and bits [11:10] equal 01. Any other accepted word completes with `done_undef`=1 and `wb_en`=0.
- R2: The message word is lane `k` of the third operand, bits [32k+31:32k], where `k` is instruction bits [13:12].
- R3: Result bits [127:96] equal the sum, modulo 2^32, of four terms. The terms are maj(a3,a1,a2), a0, (b3 XOR rotl(a3,12)) and the message word. Here aN is accumulator lane N, b3 is the top lane of the second operand, and maj(x,y,z) = (x&y)|(x&z)|(y&z). A carry out of bit 31 is dropped.
- R4: Result bits [31:0] equal accumulator [63:32]. Result bits [63:32] equal accumulator [95:64] rotated left by 9. Result bits [95:64] equal accumulator [127:96].
- R5: The read indices follow the instruction combinationally: `rf_a_idx` = bits [4:0], `rf_b_idx` = bits [9:5] and `rf_c_idx` = bits [20:16].
- R6: An instruction accepted on a clock edge (`in_valid` and `in_ready` both high) shows `done_valid`=1 after the next edge, with `wb_idx` equal to its bits [4:0]. Instructions may be accepted on consecutive cycles.
- R7: `done_valid` is low in every cycle that does not follow an acceptance. The latency does not depend on operand values or on the instruction bits.
- R8: During reset, `in_ready`, `done_valid` and `wb_en` are 0. `in_ready` becomes 1 from the second cycle after reset is released.
- R9: `wb_en` is high exactly when `done_valid` is high and `done_undef` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Unit can accept an instruction this cycle |
| in_instr | input | 32 | Instruction word |
| rf_a_idx | output | 5 | Read index for the accumulator/destination vector |
| rf_b_idx | output | 5 | Read index for the second source |
| rf_c_idx | output | 5 | Read index for the third source |
| rf_a_data | input | 128 | Accumulator vector, returned combinationally |
| rf_b_data | input | 128 | Second source vector |
| rf_c_data | input | 128 | Third source vector |
| done_valid | output | 1 | An instruction completed this cycle |
| done_undef | output | 1 | The completed word was not a valid encoding |
| wb_en | output | 1 | Write `wb_data` to register `wb_idx` |
| wb_idx | output | 5 | Destination register index |
| wb_data | output | 128 | Result vector |

## Verification
The bench flips each fixed opcode bit in turn. A decoder that ignored any one of them would write back a result where it should raise the undefined flag. It uses all four lane indices with distinct lane contents, so a reversed or stuck lane select gives the wrong top lane. It also uses all-ones operands that force the four-term sum past 2^32, so a widened or saturating adder would be caught. Back-to-back issue and idle gaps expose a result that is delayed, repeated or emitted spuriously. A rotate in the wrong direction or by the wrong amount shows up in lanes 1 and 3.

// File: rtl/sm3s_pkg.sv
package sm3s_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int LANE_W = 32;
    localparam int LANES  = 4;
    localparam int VEC_W  = LANE_W * LANES;
    localparam int RIDX_W = 5;
    localparam int LSEL_W = $clog2(LANES);

    // fixed opcode fields: upper group [31:21], two middle pairs
    localparam logic [10:0] OPC_HI  = 11'b11001110010;
    localparam logic [1:0]  OPC_MID = 2'b10;
    localparam logic [1:0]  OPC_LO  = 2'b01;

    typedef logic [LANE_W-1:0] lane_t;
    typedef logic [VEC_W-1:0]  vec_t;
    typedef logic [RIDX_W-1:0] ridx_t;

    typedef struct packed {
        logic              match;
        ridx_t             dst;
        ridx_t             srcb;
        ridx_t             srcc;
        logic [LSEL_W-1:0] lsel;
    } dec_t;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_IDLE   = 2'd1,
        ST_RESULT = 2'd2
    } st_e;

    function automatic lane_t rotl(lane_t x, int unsigned s);
        return (x << s) | (x >> (LANE_W - s));
    endfunction
endpackage

// File: rtl/sm3s_decode.sv
module sm3s_decode
    import sm3s_pkg::*;
(
    input  logic [31:0] instr,
    output dec_t        dec
);
    timeunit 1ns;
    timeprecision 1ps;

    logic hi_ok, mid_ok, lo_ok;

    always_comb begin
        hi_ok     = (instr[31:21] == OPC_HI);
        mid_ok    = (instr[15:14] == OPC_MID);
        lo_ok     = (instr[11:10] == OPC_LO);
        dec.match = hi_ok && mid_ok && lo_ok;
        dec.dst   = instr[4:0];
        dec.srcb  = instr[9:5];
        dec.srcc  = instr[20:16];
        dec.lsel  = instr[13:12];
    end
endmodule

// File: rtl/sm3s_datapath.sv
module sm3s_datapath
    import sm3s_pkg::*;
#(
    parameter int unsigned ROT_SS  = 12,
    parameter int unsigned ROT_MID = 9
) (
    input  vec_t              acc,
    input  vec_t              srcb,
    input  vec_t              srcc,
    input  logic [LSEL_W-1:0] lsel,
    output vec_t              res
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int TOP     = LANES - 1;
    localparam int MID_IDX = 1;

    lane_t a_top, a_one, a_two, a_bot, b_top;
    lane_t maj, ss2, msg, sum;

    always_comb begin
        a_top = acc[TOP*LANE_W +: LANE_W];
        a_one = acc[1*LANE_W +: LANE_W];
        a_two = acc[2*LANE_W +: LANE_W];
        a_bot = acc[0 +: LANE_W];
        b_top = srcb[TOP*LANE_W +: LANE_W];
    end

    // lane select: fixed mux, no data-dependent timing
    always_comb begin
        msg = '0;
        for (int k = 0; k < LANES; k++) begin
            if (lsel == LSEL_W'(k)) msg = srcc[k*LANE_W +: LANE_W];
        end
    end

    always_comb begin
        maj = (a_top & a_one) | (a_top & a_two) | (a_one & a_two);
        ss2 = b_top ^ rotl(a_top, ROT_SS);
        sum = maj + a_bot + ss2 + msg;
    end

    assign res[TOP*LANE_W +: LANE_W] = sum;

    for (genvar k = 0; k < LANES - 1; k++) begin : g_shift
        if (k == MID_IDX) begin : g_rot
            assign res[k*LANE_W +: LANE_W] = rotl(acc[(k+1)*LANE_W +: LANE_W], ROT_MID);
        end else begin : g_pass
            assign res[k*LANE_W +: LANE_W] = acc[(k+1)*LANE_W +: LANE_W];
        end
    end
endmodule

// File: rtl/sm3s_ctrl.sv
module sm3s_ctrl
    import sm3s_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic in_ready,
    output logic accept,
    output logic done_valid
);
    timeunit 1ns;
    timeprecision 1ps;

    st_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        in_ready   = 1'b0;
        done_valid = 1'b0;
        unique case (state)
            ST_OFF:    begin in_ready = 1'b0; done_valid = 1'b0; end
            ST_IDLE:   begin in_ready = 1'b1; done_valid = 1'b0; end
            ST_RESULT: begin in_ready = 1'b1; done_valid = 1'b1; end
            default:   begin in_ready = 1'b0; done_valid = 1'b0; end
        endcase
        accept = in_valid && in_ready;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:    state_nx = ST_IDLE;
            ST_IDLE:   state_nx = accept ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_nx = accept ? ST_RESULT : ST_IDLE;
            default:   state_nx = ST_OFF;
        endcase
    end

    // R8: ready comes up one cycle after leaving the reset state
    a_r8_ready_after_off: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |=> in_ready);
endmodule

// File: rtl/sm3s_step_unit.sv
module sm3s_step_unit
    import sm3s_pkg::*;
#(
    parameter int unsigned ROT_SS  = 12,
    parameter int unsigned ROT_MID = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [31:0]         in_instr,
    output logic [RIDX_W-1:0]   rf_a_idx,
    output logic [RIDX_W-1:0]   rf_b_idx,
    output logic [RIDX_W-1:0]   rf_c_idx,
    input  logic [VEC_W-1:0]    rf_a_data,
    input  logic [VEC_W-1:0]    rf_b_data,
    input  logic [VEC_W-1:0]    rf_c_data,
    output logic                done_valid,
    output logic                done_undef,
    output logic                wb_en,
    output logic [RIDX_W-1:0]   wb_idx,
    output logic [VEC_W-1:0]    wb_data
);
    timeunit 1ns;
    timeprecision 1ps;

    dec_t  dec;
    vec_t  res;
    logic  accept;
    vec_t  res_q;
    ridx_t idx_q;
    logic  undef_q;

    sm3s_decode u_dec (
        .instr (in_instr),
        .dec   (dec)
    );

    sm3s_datapath #(.ROT_SS(ROT_SS), .ROT_MID(ROT_MID)) u_dp (
        .acc  (rf_a_data),
        .srcb (rf_b_data),
        .srcc (rf_c_data),
        .lsel (dec.lsel),
        .res  (res)
    );

    sm3s_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .accept     (accept),
        .done_valid (done_valid)
    );

    assign rf_a_idx = dec.dst;
    assign rf_b_idx = dec.srcb;
    assign rf_c_idx = dec.srcc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q   <= '0;
            idx_q   <= '0;
            undef_q <= 1'b0;
        end else if (accept) begin
            res_q   <= res;
            idx_q   <= dec.dst;
            undef_q <= !dec.match;
        end
    end

    assign wb_data    = res_q;
    assign wb_idx     = idx_q;
    assign done_undef = done_valid && undef_q;
    assign wb_en      = done_valid && !undef_q;

    // R9: a write never happens without a clean completion
    a_r9_wb_gated: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (done_valid && !done_undef));
    // R6: completion one cycle after acceptance, carrying the destination
    a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (done_valid && wb_idx == $past(in_instr[4:0])));
    // R7: no completion without a preceding acceptance
    a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> !done_valid);
    // R1: a mismatching word completes as undefined with no write
    a_r1_undef_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !dec.match) |=> (done_undef && !wb_en));
    // R4: shifted lanes come from the accumulator read in the accept cycle
    a_r4_lane_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=>
        (wb_data[95:64] == $past(rf_a_data[127:96]) && wb_data[31:0] == $past(rf_a_data[63:32])));
endmodule

// File: tb/test_sm3s_step_unit.sv
module test_sm3s_step_unit;
    timeunit 1ns;
    timeprecision 1ps;

    typedef struct {
        logic         undef;
        logic [4:0]   idx;
        logic [127:0] data;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [31:0]  in_instr = '0;
    logic [4:0]   rf_a_idx, rf_b_idx, rf_c_idx;
    logic [127:0] rf_a_data, rf_b_data, rf_c_data;
    logic         done_valid, done_undef, wb_en;
    logic [4:0]   wb_idx;
    logic [127:0] wb_data;

    logic [127:0] rf [32];
    exp_t         sb [$];
    int           n_cmp = 0;
    int           n_bad = 0;

    always #4 clk = ~clk; // 125 MHz

    assign rf_a_data = rf[rf_a_idx];
    assign rf_b_data = rf[rf_b_idx];
    assign rf_c_data = rf[rf_c_idx];

    sm3s_step_unit i_sm3s_step_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_instr(in_instr), .rf_a_idx(rf_a_idx), .rf_b_idx(rf_b_idx),
        .rf_c_idx(rf_c_idx), .rf_a_data(rf_a_data), .rf_b_data(rf_b_data),
        .rf_c_data(rf_c_data), .done_valid(done_valid), .done_undef(done_undef),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
    );

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(input logic [4:0] rd, input logic [4:0] rn,
                                        input logic [4:0] rm, input logic [1:0] k);
        return {11'b11001110010, rm, 2'b10, k, 2'b01, rn, rd};
    endfunction

    function automatic logic [127:0] ref_step(input logic [127:0] a, input logic [127:0] b,
                                              input logic [127:0] c, input logic [1:0] k);
        logic [31:0] x, y, z, m, s, w, t;
        x = a[127:96]; y = a[63:32]; z = a[95:64];
        m = (x & y) | (x & z) | (y & z);
        s = b[127:96] ^ {x[19:0], x[31:20]};
        w = c[32*k +: 32];
        t = m + a[31:0] + s + w;
        return {t, x, {z[22:0], z[31:23]}, y};
    endfunction

    task automatic issue(input logic [31:0] w);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        in_instr = w;
        #1;
        check(rf_a_idx == w[4:0] && rf_b_idx == w[9:5] && rf_c_idx == w[20:16], "R5 read indices",
              {rf_a_idx, rf_b_idx, rf_c_idx}, {w[4:0], w[9:5], w[20:16]});
        check(in_ready == 1'b1, "R8 ready", 128'(in_ready), 128'd1);
        e.undef = !(w[31:21] == 11'b11001110010 && w[15:14] == 2'b10 && w[11:10] == 2'b01);
        e.idx   = w[4:0];
        e.data  = ref_step(rf[w[4:0]], rf[w[9:5]], rf[w[20:16]], w[13:12]);
        @(posedge clk);
        sb.push_back(e);
    endtask

    task automatic idle(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b0;
        in_instr = w;
        @(posedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R7 unexpected completion", 128'(done_valid), 128'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(done_undef == e.undef, "R1 undef flag", 128'(done_undef), 128'(e.undef));
                    check(wb_en == !e.undef, "R9 write enable", 128'(wb_en), 128'(!e.undef));
                    if (!e.undef) begin
                        check(wb_idx == e.idx, "R6 destination", 128'(wb_idx), 128'(e.idx));
                        check(wb_data[127:96] == e.data[127:96], "R2 R3 top lane",
                              128'(wb_data[127:96]), 128'(e.data[127:96]));
                        check(wb_data[95:0] == e.data[95:0], "R4 shifted lanes",
                              128'(wb_data[95:0]), 128'(e.data[95:0]));
                    end
                end
            end else begin
                check(wb_en == 1'b0, "R9 no write when idle", 128'(wb_en), 128'd0);
                if (sb.size() != 0) begin
                    check(1'b0, "R6 missing completion", 128'(done_valid), 128'd1);
                    void'(sb.pop_front());
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        n_bad++;
        n_cmp++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int r = 0; r < 32; r++) begin
            rf[r] = {$urandom(), $urandom(), $urandom(), $urandom()};
        end
        rf[31] = '1;                                  // wrap operand
        rf[30] = '0;
        rf[29] = {32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111};

        repeat (3) @(negedge clk);
        check(in_ready == 1'b0 && done_valid == 1'b0 && wb_en == 1'b0, "R8 reset outputs",
              {in_ready, done_valid, wb_en}, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(in_ready == 1'b1, "R8 ready after reset", 128'(in_ready), 128'd1);
        check(done_valid == 1'b0, "R7 idle after reset", 128'(done_valid), 128'd0);

        // R2: every lane index with distinct lane contents
        for (int k = 0; k < 4; k++) begin
            issue(enc(5'd3, 5'd7, 5'd29, 2'(k)));
        end
        // R3: wrap of the four-term sum: all ones gives fffffffc on top
        issue(enc(5'd31, 5'd30, 5'd31, 2'd0));
        check(ref_step('1, '0, '1, 2'd0) == {32'hffff_fffc, 96'hffffffff_ffffffff_ffffffff},
              "R3 wrap reference", ref_step('1, '0, '1, 2'd0),
              {32'hffff_fffc, 96'hffffffff_ffffffff_ffffffff});
        issue(enc(5'd31, 5'd31, 5'd31, 2'd3));
        idle(enc(5'd1, 5'd2, 5'd3, 2'd1));
        idle('0);

        // back-to-back mixed traffic with gaps (R6, R7)
        for (int n = 0; n < 40; n++) begin
            logic [31:0] u;
            u = $urandom();
            issue(enc(u[4:0], u[9:5], u[20:16], u[13:12]));
            if (u[31:30] == 2'b00) idle(u);
        end

        // R1: flip each fixed opcode bit in turn
        for (int b = 0; b < 32; b++) begin
            if (b >= 21 || b == 15 || b == 14 || b == 11 || b == 10) begin
                logic [31:0] g;
                g = enc(5'd4, 5'd5, 5'd6, 2'd2);
                g[b] = ~g[b];
                issue(g);
            end
        end
        issue(32'h0000_0000);
        issue(enc(5'd9, 5'd10, 5'd11, 2'd1));
        idle('0);
        idle('0);
        idle('0);

        check(sb.size() == 0, "R6 scoreboard drained", 128'(sb.size()), 128'd0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule